// File: doc/BRIEF.md
# Cascadable Framed Byte-Capture Receiver

This block sits behind a deserializer and symbol decoder. Once per byte period the decoder hands it one symbol with a 12-bit word, flagged as a sync symbol, a data symbol or a command symbol. The block chooses which symbols reach its parallel outputs and splits the 12 bits between a data field and a command field according to a width selector. Each time it presents a symbol it raises a data strobe or a command strobe at mid-byte. It also drives a byte-rate clock.

A claim input (`catch_en`) and a claim-done output (`got_mine`) let several receivers share one framed stream. With `catch_en` tied to the block's own `byte_clk`, every symbol is presented (local mode). With `catch_en` held high, the block keeps only the first non-sync symbol after a sync and presents it when the next sync arrives. When each receiver's `catch_en` is fed from the previous receiver's `got_mine`, the receivers in the chain pick off successive bytes of a frame.

Timing comes from two single-cycle enables. `load_en` marks the arrival of a symbol. `mid_en` marks the middle of the byte period and never falls in the same cycle as `load_en`.

Top module: `rxc_receiver`

## Requirements
- R1: Synchronous reset clears all parallel output lanes and both strobes, and sets `byte_clk` and `got_mine` high. The capture logic is left armed.
- R2: When a data symbol is presented, output lanes 0..N-1 take word bits 0..N-1. N is 8 for `mode_sel`=00, 9 for 01 and 10 for 10 or 11. Lanes 0..7 are `par_data`, lane 8 is `par_mix[0]` and lane 9 is `par_mix[1]`.
- R3: When a command symbol is presented, its M=12-N command bits go to their lanes: bit 0 to `par_cmd[0]`, bit 1 to `par_cmd[1]`, bit 2 (when M>=3) to `par_mix[1]`, and bit 3 (when M=4) to `par_mix[0]`.
- R4: A presentation changes only the lanes owned by its own kind in the current mode. Every other lane keeps the most recent value of its kind, and lanes change only in the cycle after `mid_en`.
- R5: A presentation raises `data_stb` (for a data symbol) or `cmd_stb` (for a command symbol) in the cycle after `mid_en`. The other strobe stays low. Both strobes are low in the cycle after `load_en`.
- R6: `byte_clk` goes low in the cycle after `load_en` and goes high in the cycle after `mid_en`.
- R7: With `catch_en` tied to `byte_clk`, every non-sync symbol is presented at the mid-byte of its own byte period, and sync symbols present nothing.
- R8: With `catch_en` high, only the first non-sync symbol after a sync is captured. It is presented at the mid-byte of the next sync symbol. A sync symbol is never captured, whatever its command flag.
- R9: A low level on `catch_en` acts as a decoded sync. Any captured symbol is presented at the following mid-byte, capture is re-armed, and no symbol loaded while `catch_en` is low is captured.
- R10: At each `mid_en`, `got_mine` goes low if the last loaded symbol was a sync. It goes high if that symbol was non-sync and `catch_en` was high when it loaded. Otherwise it holds.
- R11: A receiver whose `catch_en` is driven by an upstream `got_mine` (the upstream one having `catch_en` high) captures the second non-sync symbol after a sync, while the upstream receiver captures the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Symbol-load pulse, once per byte |
| mid_en | input | 1 | Mid-byte pulse, half a byte after load |
| sym_sync | input | 1 | Loaded symbol is a sync |
| sym_cmd | input | 1 | Loaded non-sync symbol is a command (else data) |
| sym_word | input | 12 | Decoded symbol payload |
| mode_sel | input | 2 | Field split: 00 8/4, 01 9/3, 1x 10/2 |
| catch_en | input | 1 | Claim input; low acts as sync |
| byte_clk | output | 1 | Byte-rate clock |
| par_data | output | 8 | Data lanes 0..7 |
| par_mix | output | 2 | Lane 8 (data 8 / cmd 3), lane 9 (data 9 / cmd 2) |
| par_cmd | output | 2 | Command bits 0 and 1 |
| data_stb | output | 1 | New data presented |
| cmd_stb | output | 1 | New command presented |
| got_mine | output | 1 | Claim-done handshake to downstream |

## Verification
The bench goes after the shared lanes 8 and 9. If a data presentation in the 8/4 split overwrote command bits there, the directed lane values would show it. The bench pulses `catch_en` low after a load. A design that ignored that low level would keep the captured byte until the next real sync, which misses the expected mid-byte strobe. It also chains two receivers over random frames. If the downstream claim were mistimed, the second receiver would repeat the first byte or take the third one.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int WORD_W   = 12;
    localparam int DATA_MAX = 10;
    localparam int CMD_MAX  = 4;

    typedef struct packed {
        logic              is_cmd;
        logic [WORD_W-1:0] word;
    } sym_t;

    function automatic int data_width(input logic [1:0] m);
        case (m)
            2'b00:   return 8;
            2'b01:   return 9;
            default: return 10;
        endcase
    endfunction

    // output lane carrying command bit j
    function automatic logic [3:0] cmd_lane(input int j);
        case (j)
            0:       return 4'd10;
            1:       return 4'd11;
            2:       return 4'd9;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/rxc_lane_map.sv
module rxc_lane_map
    import rxc_pkg::*;
(
    input  logic [1:0]        mode_sel,
    input  logic              is_cmd,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] bus_q,
    output logic [WORD_W-1:0] bus_d
);
    int dw;

    always_comb begin
        bus_d = bus_q;
        dw    = data_width(mode_sel);
        if (!is_cmd) begin
            for (int i = 0; i < DATA_MAX; i++) begin
                if (i < dw) bus_d[i] = word[i];
            end
        end else begin
            for (int j = 0; j < CMD_MAX; j++) begin
                if (j < WORD_W - dw) bus_d[cmd_lane(j)] = word[j];
            end
        end
    end
endmodule

// File: rtl/rxc_capture.sv
module rxc_capture
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              take_en,
    input  logic              sym_sync,
    input  logic              sym_cmd,
    input  logic [WORD_W-1:0] sym_word,
    input  logic              catch_en,
    output logic              stage_v,
    output sym_t              stage_sym
);
    typedef struct packed {
        logic armed;
        logic held_v;
        sym_t held;
        logic stage_v;
        sym_t stage;
    } cap_t;

    localparam cap_t CAP_RST = '{armed: 1'b1, held_v: 1'b0, held: '0,
                                 stage_v: 1'b0, stage: '0};

    cap_t st_q, st_d;
    logic sync_evt;

    always_comb begin
        st_d     = st_q;
        sync_evt = (load_en && sym_sync) || !catch_en;
        if (take_en) st_d.stage_v = 1'b0;
        if (sync_evt) begin
            st_d.armed = 1'b1;
            if (st_q.held_v) begin
                st_d.stage_v = 1'b1;
                st_d.stage   = st_q.held;
                st_d.held_v  = 1'b0;
            end
        end else if (load_en && st_q.armed) begin
            st_d.held_v      = 1'b1;
            st_d.held.is_cmd = sym_cmd;
            st_d.held.word   = sym_word;
            st_d.armed       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CAP_RST;
        else     st_q <= st_d;
    end

    assign stage_v   = st_q.stage_v;
    assign stage_sym = st_q.stage;

    // R9: armed and holding a capture are mutually exclusive
    a_r9_arm_excl: assert property (@(posedge clk) disable iff (rst)
        !(st_q.armed && st_q.held_v));
    // R8: a capture only follows a load with the claim input high
    a_r8_capture_needs_catch: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.held_v) |-> $past(load_en && catch_en && !sym_sync));
endmodule

// File: rtl/rxc_receiver.sv
module rxc_receiver
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              mid_en,
    input  logic              sym_sync,
    input  logic              sym_cmd,
    input  logic [WORD_W-1:0] sym_word,
    input  logic [1:0]        mode_sel,
    input  logic              catch_en,
    output logic              byte_clk,
    output logic [7:0]        par_data,
    output logic [1:0]        par_mix,
    output logic [1:0]        par_cmd,
    output logic              data_stb,
    output logic              cmd_stb,
    output logic              got_mine
);
    typedef struct packed {
        logic              bclk;
        logic              dstb;
        logic              cstb;
        logic              igm;
        logic              last_sync;
        logic              last_catch;
        logic [WORD_W-1:0] bus;
    } rx_t;

    localparam rx_t RX_RST = '{bclk: 1'b1, dstb: 1'b0, cstb: 1'b0, igm: 1'b1,
                               last_sync: 1'b0, last_catch: 1'b1, bus: '0};

    rx_t               r_q, r_d;
    logic              stage_v;
    sym_t              stage_sym;
    logic [WORD_W-1:0] map_bus;

    rxc_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .take_en  (mid_en),
        .sym_sync (sym_sync),
        .sym_cmd  (sym_cmd),
        .sym_word (sym_word),
        .catch_en (catch_en),
        .stage_v  (stage_v),
        .stage_sym(stage_sym)
    );

    rxc_lane_map u_lane_map (
        .mode_sel(mode_sel),
        .is_cmd  (stage_sym.is_cmd),
        .word    (stage_sym.word),
        .bus_q   (r_q.bus),
        .bus_d   (map_bus)
    );

    always_comb begin
        r_d = r_q;
        if (load_en) begin
            r_d.bclk       = 1'b0;
            r_d.dstb       = 1'b0;
            r_d.cstb       = 1'b0;
            r_d.last_sync  = sym_sync;
            r_d.last_catch = catch_en;
        end
        if (mid_en) begin
            r_d.bclk = 1'b1;
            if (r_q.last_sync)       r_d.igm = 1'b0;
            else if (r_q.last_catch) r_d.igm = 1'b1;
            if (stage_v) begin
                r_d.bus  = map_bus;
                r_d.dstb = !stage_sym.is_cmd;
                r_d.cstb = stage_sym.is_cmd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RX_RST;
        else     r_q <= r_d;
    end

    assign byte_clk = r_q.bclk;
    assign par_data = r_q.bus[7:0];
    assign par_mix  = r_q.bus[9:8];
    assign par_cmd  = r_q.bus[11:10];
    assign data_stb = r_q.dstb;
    assign cmd_stb  = r_q.cstb;
    assign got_mine = r_q.igm;

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(load_en && mid_en));
    a_r5_dstb_at_mid: assert property (@(posedge clk) disable iff (rst)
        $rose(data_stb) |-> $past(mid_en));
    a_r5_cstb_at_mid: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_stb) |-> $past(mid_en));
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(data_stb && cmd_stb));
    a_r5_drop_on_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (!data_stb && !cmd_stb));
    a_r6_bclk_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(byte_clk) |-> $past(load_en));
    a_r6_bclk_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_clk) |-> $past(mid_en));
    a_r10_igm_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(got_mine) |-> $past(mid_en));
    a_r4_lanes_at_mid: assert property (@(posedge clk) disable iff (rst)
        !$stable({par_cmd, par_mix, par_data}) |-> $past(mid_en));
endmodule

// File: tb/rxc_receiver_tb_top.sv
`timescale 1ns/1ps
module rxc_receiver_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0, mid_en = 1'b0;
    logic        sym_sync = 1'b0, sym_cmd = 1'b0;
    logic [11:0] sym_word = '0;
    logic [1:0]  mode_sel = 2'b00;
    logic        local_sel = 1'b0, catch_drv = 1'b1;
    logic        catch_i;
    logic        bclk_i, dstb_i, cstb_i, igm_i;
    logic [7:0]  pd_i, pd_c;
    logic [1:0]  pm_i, pc_i, pm_c, pc_c;
    logic        bclk_c, dstb_c, cstb_c, igm_c;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    assign catch_i = local_sel ? bclk_i : catch_drv;

    rxc_receiver dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .mid_en(mid_en),
        .sym_sync(sym_sync), .sym_cmd(sym_cmd), .sym_word(sym_word),
        .mode_sel(mode_sel), .catch_en(catch_i), .byte_clk(bclk_i),
        .par_data(pd_i), .par_mix(pm_i), .par_cmd(pc_i),
        .data_stb(dstb_i), .cmd_stb(cstb_i), .got_mine(igm_i));

    rxc_receiver dut_c (
        .clk(clk), .rst(rst), .load_en(load_en), .mid_en(mid_en),
        .sym_sync(sym_sync), .sym_cmd(sym_cmd), .sym_word(sym_word),
        .mode_sel(mode_sel), .catch_en(igm_i), .byte_clk(bclk_c),
        .par_data(pd_c), .par_mix(pm_c), .par_cmd(pc_c),
        .data_stb(dstb_c), .cmd_stb(cstb_c), .got_mine(igm_c));

    // reference state, index 0 = dut_i, 1 = dut_c
    bit          m_armed[2], m_hv[2], m_hc[2], m_igm[2], e_d[2], e_c[2];
    logic [11:0] m_hw[2], m_bus[2];

    function automatic logic [11:0] exp_map(input logic [1:0] md, input bit isc,
                                            input logic [11:0] w, input logic [11:0] old);
        logic [11:0] r = old;
        int n = (md == 2'b00) ? 8 : (md == 2'b01) ? 9 : 10;
        if (!isc) begin
            r[7:0] = w[7:0];
            if (n >= 9)  r[8] = w[8];
            if (n == 10) r[9] = w[9];
        end else begin
            r[10] = w[0];
            r[11] = w[1];
            if (n <= 9) r[9] = w[2];
            if (n == 8) r[8] = w[3];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_armed[k] = 1; m_hv[k] = 0; m_hc[k] = 0; m_hw[k] = '0;
            m_bus[k] = '0; m_igm[k] = 1; e_d[k] = 0; e_c[k] = 0;
        end
    endtask

    task automatic model_load(input int k, input bit s, input bit c, input logic [11:0] w,
                              input logic [1:0] md, input bit cnb_load, input bit post_low);
        bit pres = 0;
        bit pc = 0;
        logic [11:0] pw = '0;
        if (s || !cnb_load) begin
            if (m_hv[k]) begin pres = 1; pc = m_hc[k]; pw = m_hw[k]; m_hv[k] = 0; end
            m_armed[k] = 1;
        end else if (m_armed[k]) begin
            m_hv[k] = 1; m_hc[k] = c; m_hw[k] = w; m_armed[k] = 0;
        end
        if (post_low) begin
            if (m_hv[k]) begin pres = 1; pc = m_hc[k]; pw = m_hw[k]; m_hv[k] = 0; end
            m_armed[k] = 1;
        end
        e_d[k] = pres && !pc;
        e_c[k] = pres && pc;
        if (pres) m_bus[k] = exp_map(md, pc, pw, m_bus[k]);
        if (s) m_igm[k] = 0;
        else if (cnb_load) m_igm[k] = 1;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
        chk("R1 reset lanes", {pc_i, pm_i, pd_i}, 12'h000);
        chk("R1 reset strobes", {dstb_i, cstb_i}, 2'b00);
        chk("R1 reset got_mine", igm_i, 1);
        chk("R1 reset byte_clk", bclk_i, 1);
    endtask

    task automatic run_byte(input bit s, input bit c, input logic [11:0] w,
                            input logic [1:0] md, input bit pulse);
        bit    igm0_old = m_igm[0];
        string tag0;
        sym_sync = s; sym_cmd = c; sym_word = w; mode_sel = md; load_en = 1;
        @(negedge clk);
        load_en = 0;
        chk("R6 byte_clk low after load", bclk_i, 0);
        chk("R5 strobes low after load", {dstb_i, cstb_i}, 2'b00);
        model_load(0, s, c, w, md, 1'b1, local_sel || pulse);
        model_load(1, s, c, w, md, igm0_old, 1'b0);
        if (pulse) catch_drv = 0;
        @(negedge clk);
        catch_drv = 1;
        @(negedge clk);
        mid_en = 1;
        @(negedge clk);
        mid_en = 0;
        tag0 = local_sel ? "R7 local lanes" : (pulse ? "R9 catch-low lanes" : "R8 catch-high lanes");
        chk(tag0, {pc_i, pm_i, pd_i}, m_bus[0]);
        chk("R5 data strobe", dstb_i, e_d[0]);
        chk("R5 command strobe", cstb_i, e_c[0]);
        chk("R6 byte_clk high after mid", bclk_i, 1);
        if (!local_sel) begin
            chk("R10 got_mine", igm_i, m_igm[0]);
            chk("R11 downstream lanes", {pc_c, pm_c, pd_c}, m_bus[1]);
            chk("R11 downstream strobes", {dstb_c, cstb_c}, {e_d[1], e_c[1]});
            chk("R11 downstream got_mine", igm_c, m_igm[1]);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        @(negedge clk);
        do_reset();

        // directed lane split in local mode
        local_sel = 1;
        run_byte(1, 0, 12'h000, 2'b00, 0);
        run_byte(0, 0, 12'hFFF, 2'b00, 0);
        chk("R2 data 8/4 lanes", {pc_i, pm_i, pd_i}, 12'h0FF);
        run_byte(0, 1, 12'h00F, 2'b00, 0);
        chk("R3 cmd 8/4 lanes", {pc_i, pm_i, pd_i}, 12'hFFF);
        run_byte(0, 0, 12'h000, 2'b10, 0);
        chk("R4 data 10/2 keeps cmd lanes", {pc_i, pm_i, pd_i}, 12'hC00);
        run_byte(0, 1, 12'h005, 2'b01, 0);
        chk("R3 cmd 9/3 lanes", {pc_i, pm_i, pd_i}, 12'h600);
        run_byte(0, 0, 12'h1AA, 2'b01, 0);
        chk("R2 data 9/3 keeps lane 9", {pc_i, pm_i, pd_i}, 12'h7AA);
        run_byte(1, 1, 12'hABC, 2'b01, 0);
        chk("R7 sync presents nothing", {dstb_i, cstb_i}, 2'b00);
        for (int n = 0; n < 40; n++)
            run_byte(($urandom % 4) == 0, $urandom % 2, 12'($urandom), 2'($urandom), 0);

        // cascade, directed frame
        local_sel = 0;
        do_reset();
        run_byte(1, 0, 12'h000, 2'b10, 0);
        chk("R10 got_mine low after sync", igm_i, 0);
        run_byte(0, 0, 12'h011, 2'b10, 0);
        run_byte(0, 0, 12'h022, 2'b10, 0);
        run_byte(0, 0, 12'h033, 2'b10, 0);
        run_byte(1, 1, 12'hFFF, 2'b10, 0);
        chk("R8 upstream takes first byte", {pc_i, pm_i, pd_i}, 12'h011);
        chk("R11 downstream takes second byte", {pc_c, pm_c, pd_c}, 12'h022);

        // catch low acts as sync
        run_byte(0, 1, 12'h003, 2'b10, 0);
        run_byte(0, 0, 12'h044, 2'b10, 1);
        chk("R9 pulse presents held command", {cstb_i, pc_i}, 3'b111);
        run_byte(0, 0, 12'h055, 2'b10, 0);
        run_byte(0, 0, 12'h066, 2'b10, 1);
        chk("R9 re-armed capture presented", pd_i, 8'h55);

        for (int n = 0; n < 300; n++)
            run_byte(($urandom % 4) == 0, $urandom % 2, 12'($urandom), 2'($urandom),
                     ($urandom % 16) == 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule